// File: doc/BRIEF.md
# Video Encoder Control Register Bank

This block holds the software-visible settings of a composite video encoder. A host writes it through an 8-bit parallel bus with a 6-bit address, an active-low select and an active-low write strobe. A write commits on the rising edge of the strobe. The strobe is brought into the encoder clock domain before the stored value changes, so every register changes on an encoder clock edge. The read bus is purely combinational. It always shows the register that the address selects, whatever the levels on select and strobe.

The bank holds a first control register (auto-register flag, auto-standard flag, standard code), a second control register (filter, colour, blanking and timing-source flags), a pre-emphasis level and six representative timing and gain registers. The block resolves the effective output standard from the standard code and, in auto-standard mode, from a line-count detection input. In auto-register mode, built-in per-standard presets drive the effective timing and gain outputs. The stored timing registers remain writable and readable. The two control registers and the pre-emphasis level always act directly.

Top module: `vid_ctl_regbank`

## Requirements
- R1: A write commits when `wr_n` goes low to high while `cs_n` is low. The target register shows the new value within 3 rising clock edges of the strobe rise. A falling edge of `wr_n`, or `wr_n` held low, changes nothing.
- R2: A `wr_n` rising edge that occurs while `cs_n` is high changes no register.
- R3: `rdata` depends only on `addr`. It returns the stored (not effective) value of the addressed register for any levels of `cs_n` and `wr_n`.
- R4: The address map is: control 1 at 0x00, control 2 at 0x01, pre-emphasis at 0x02, timing registers 0 to 5 at 0x08 to 0x0D. A write to any other address is discarded, and a read of any other address returns 0x00. Control 1 bits 3:0 and control 2 bits 7:6 always read as zero.
- R5: Reset gives these values:
  - control 1 = 0xC0 (auto-register bit 7 set, auto-standard bit 6 set, standard code bits 5:4 = 00);
  - control 2 = 0x30 (sinx/x enable bit 5 = 1, luma comb bit 4 = 1, chroma off bit 3 = 0, VBI pass bit 2 = 0, blackburst bit 1 = 0, free-run bit 0 = 0);
  - pre-emphasis = 0x00;
  - timing registers = the NTSC-M presets.
- R6: With auto-standard clear, `std_sel` equals control 1 bits 5:4. The code meanings are 00 NTSC-M, 01 PAL-M, 10 PAL, 11 PAL-N.
- R7: With auto-standard set, `std_sel[1]` equals `line625_det` and `std_sel[0]` equals control 1 bit 4.
- R8: With auto-register set, each effective timing output equals the preset for `std_sel`. The presets, listed as NTSC-M / PAL-M / PAL / PAL-N, are:
  - hsync width: 63/62/64/65;
  - burst start: 19/20/22/21;
  - burst length: 36/37/40/38;
  - luma gain: 128/120/132/124;
  - chroma gain: 150/144/160/154;
  - VBI gain: 100/102/104/106.
- R9: With auto-register clear, each effective timing output equals its stored register.
- R10: The six control 2 flag outputs and `eff_preemph` follow the stored registers in both auto-register settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line625_det | input | 1 | High when the input is detected as 625-line |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe, commit on rising edge |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback of addressed stored register |
| std_sel | output | 2 | Effective standard code |
| sinc_en | output | 1 | Sinx/x compensation enable |
| comb_en | output | 1 | Luma comb enable |
| chroma_off | output | 1 | Force monochrome |
| vbi_pass | output | 1 | VBI pass-through |
| blackburst | output | 1 | Blanked burst-only output |
| freerun | output | 1 | Internal timing source |
| eff_preemph | output | 8 | Pre-emphasis level |
| eff_hsync_w | output | 8 | Effective hsync width |
| eff_burst_start | output | 8 | Effective burst start |
| eff_burst_len | output | 8 | Effective burst length |
| eff_luma_gain | output | 8 | Effective luma gain |
| eff_chroma_gain | output | 8 | Effective chroma gain |
| eff_vbi_gain | output | 8 | Effective VBI gain |

## Verification
The assertions take for granted that `cs_n`, `addr` and `wdata` stay stable from before the strobe rise until the synchronised commit. They also assume that each strobe level lasts at least two clock periods, so the synchroniser sees every edge. The stimulus changes bus inputs only on falling clock edges. It holds the bus for four cycles after each strobe rise, and keeps both strobe phases two cycles long. In the readback-independence scenario, the select line is released before the strobe returns high, so no unintended commit occurs.

// File: rtl/vrb_pkg.sv
// Package: shared constants, standard codes and the preset function for
// the control register bank. Assumes an 8-bit data path.
package vrb_pkg;

    localparam int AW       = 6;
    localparam int DW       = 8;
    localparam int NTIM     = 6;
    localparam int TIM_BASE = 8;

    localparam logic [AW-1:0] A_CTL1 = 6'h00;
    localparam logic [AW-1:0] A_CTL2 = 6'h01;
    localparam logic [AW-1:0] A_PRE  = 6'h02;

    localparam logic [DW-1:0] CTL1_RST = 8'hC0;
    localparam logic [DW-1:0] CTL2_RST = 8'h30;

    typedef enum logic [1:0] {
        STD_NTSC_M = 2'b00,
        STD_PAL_M  = 2'b01,
        STD_PAL    = 2'b10,
        STD_PAL_N  = 2'b11
    } std_e;

    // Built-in per-standard value of timing register idx.
    function automatic logic [DW-1:0] preset_val(input logic [1:0] std, input int idx);
        logic [DW-1:0] v;
        v = '0;
        case (idx)
            0: case (std) 2'b00: v = 8'd63;  2'b01: v = 8'd62;  2'b10: v = 8'd64;  default: v = 8'd65;  endcase
            1: case (std) 2'b00: v = 8'd19;  2'b01: v = 8'd20;  2'b10: v = 8'd22;  default: v = 8'd21;  endcase
            2: case (std) 2'b00: v = 8'd36;  2'b01: v = 8'd37;  2'b10: v = 8'd40;  default: v = 8'd38;  endcase
            3: case (std) 2'b00: v = 8'd128; 2'b01: v = 8'd120; 2'b10: v = 8'd132; default: v = 8'd124; endcase
            4: case (std) 2'b00: v = 8'd150; 2'b01: v = 8'd144; 2'b10: v = 8'd160; default: v = 8'd154; endcase
            5: case (std) 2'b00: v = 8'd100; 2'b01: v = 8'd102; 2'b10: v = 8'd104; default: v = 8'd106; endcase
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vrb_wr_sync.sv
// Write strobe synchroniser: brings wr_n into clk through SYNC_STAGES flops.
// It carries cs_n, addr and wdata through an equally deep pipeline, so the
// bus values line up with the delayed strobe. It emits a one-cycle commit
// pulse on a strobe rise that has select low. Assumes the bus is stable
// around the strobe rise.
module vrb_wr_sync
    import vrb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int BUS_W = 1 + AW + DW;
    localparam int LAST  = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] wr_s;
    logic [BUS_W-1:0]       bus_s [SYNC_STAGES];
    logic                   wr_last;

    // First synchroniser stage samples the raw strobe and bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_s[0]  <= 1'b1;
            bus_s[0] <= {1'b1, {(AW+DW){1'b0}}};
        end else begin
            wr_s[0]  <= wr_n;
            bus_s[0] <= {cs_n, addr, wdata};
        end
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            // Further synchroniser stages shift strobe and bus in step.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_s[g]  <= 1'b1;
                    bus_s[g] <= {1'b1, {(AW+DW){1'b0}}};
                end else begin
                    wr_s[g]  <= wr_s[g-1];
                    bus_s[g] <= bus_s[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronised strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_last <= 1'b1;
        else        wr_last <= wr_s[LAST];
    end

    // Commit on a synchronised rise with select asserted.
    always_comb begin
        wr_pulse = wr_s[LAST] && !wr_last && !bus_s[LAST][AW+DW];
        wr_addr  = bus_s[LAST][AW+DW-1:DW];
        wr_data  = bus_s[LAST][DW-1:0];
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R1
    AST_PULSE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> wr_s[LAST]); // R1

endmodule

// File: rtl/vrb_store.sv
// Register storage: control 1 (bits 7:4), control 2 (bits 5:0), pre-emphasis
// and NTIM timing registers. A commit pulse writes the decoded register, and
// writes to unmapped addresses are dropped. Reset loads the defaults.
module vrb_store
    import vrb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_pulse,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            ctl1,
    output logic [DW-1:0]            ctl2,
    output logic [DW-1:0]            pre,
    output logic [NTIM-1:0][DW-1:0]  tim
);
    logic [3:0]              ctl1_q;
    logic [5:0]              ctl2_q;
    logic [DW-1:0]           pre_q;
    logic [NTIM-1:0][DW-1:0] tim_q;

    // Control 1 upper nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl1_q <= CTL1_RST[7:4];
        else if (wr_pulse && wr_addr == A_CTL1)  ctl1_q <= wr_data[7:4];
    end

    // Control 2 low six bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl2_q <= CTL2_RST[5:0];
        else if (wr_pulse && wr_addr == A_CTL2)  ctl2_q <= wr_data[5:0];
    end

    // Pre-emphasis level.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pre_q <= '0;
        else if (wr_pulse && wr_addr == A_PRE)   pre_q <= wr_data;
    end

    genvar i;
    generate
        for (i = 0; i < NTIM; i++) begin : g_tim
            localparam logic [AW-1:0] MY_ADDR = AW'(TIM_BASE + i);
            // Timing register i, reset to its NTSC-M preset.
            always_ff @(posedge clk) begin
                if (!rst_n)                               tim_q[i] <= preset_val(STD_NTSC_M, i);
                else if (wr_pulse && wr_addr == MY_ADDR)  tim_q[i] <= wr_data;
            end
        end
    endgenerate

    // Pad stored fields to full register width.
    always_comb begin
        ctl1 = {ctl1_q, 4'b0000};
        ctl2 = {2'b00, ctl2_q};
        pre  = pre_q;
        tim  = tim_q;
    end

    logic unmapped;
    // Unmapped-address flag for checking only.
    always_comb begin
        unmapped = !(wr_addr == A_CTL1 || wr_addr == A_CTL2 || wr_addr == A_PRE ||
                     (wr_addr >= AW'(TIM_BASE) && wr_addr < AW'(TIM_BASE + NTIM)));
    end

    AST_UNUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && unmapped) |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(pre_q) && $stable(tim_q))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(pre_q) && $stable(tim_q))); // R2

endmodule

// File: rtl/vrb_preset.sv
// Preset table: gives the built-in value of every timing register for the
// selected standard. Purely combinational.
module vrb_preset
    import vrb_pkg::*;
(
    input  logic [1:0]               std,
    output logic [NTIM-1:0][DW-1:0]  preset
);
    genvar i;
    generate
        for (i = 0; i < NTIM; i++) begin : g_pre
            // Look up preset i for the current standard.
            always_comb preset[i] = preset_val(std, i);
        end
    endgenerate
endmodule

// File: rtl/vrb_readmux.sv
// Read multiplexer: selects the stored register addressed by addr, and returns
// zero for unmapped addresses. Independent of select and strobe.
module vrb_readmux
    import vrb_pkg::*;
(
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            ctl1,
    input  logic [DW-1:0]            ctl2,
    input  logic [DW-1:0]            pre,
    input  logic [NTIM-1:0][DW-1:0]  tim,
    output logic [DW-1:0]            rdata
);
    // Address decode for readback.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL1:  rdata = ctl1;
            A_CTL2:  rdata = ctl2;
            A_PRE:   rdata = pre;
            default: begin
                for (int k = 0; k < NTIM; k++) begin
                    if (addr == AW'(TIM_BASE + k)) rdata = tim[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/vid_ctl_regbank.sv
// Top: control register bank of a video encoder. It synchronises host writes,
// stores registers, resolves the effective standard and selects preset or
// stored timing values according to the auto-register flag.
module vid_ctl_regbank
    import vrb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line625_det,
    input  logic        cs_n,
    input  logic        wr_n,
    input  logic [5:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [1:0]  std_sel,
    output logic        sinc_en,
    output logic        comb_en,
    output logic        chroma_off,
    output logic        vbi_pass,
    output logic        blackburst,
    output logic        freerun,
    output logic [7:0]  eff_preemph,
    output logic [7:0]  eff_hsync_w,
    output logic [7:0]  eff_burst_start,
    output logic [7:0]  eff_burst_len,
    output logic [7:0]  eff_luma_gain,
    output logic [7:0]  eff_chroma_gain,
    output logic [7:0]  eff_vbi_gain
);
    logic                    wr_pulse;
    logic [AW-1:0]           wr_addr;
    logic [DW-1:0]           wr_data;
    logic [DW-1:0]           ctl1, ctl2, pre;
    logic [NTIM-1:0][DW-1:0] tim, preset, eff;
    logic                    auto_reg, auto_std;

    vrb_wr_sync #(.SYNC_STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vrb_store i_store (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl1(ctl1), .ctl2(ctl2), .pre(pre), .tim(tim)
    );

    vrb_preset i_preset (.std(std_sel), .preset(preset));

    vrb_readmux i_rmux (
        .addr(addr), .ctl1(ctl1), .ctl2(ctl2), .pre(pre), .tim(tim), .rdata(rdata)
    );

    // Standard resolution and mode flags.
    always_comb begin
        auto_reg = ctl1[7];
        auto_std = ctl1[6];
        std_sel  = auto_std ? {line625_det, ctl1[4]} : ctl1[5:4];
    end

    // Effective timing: preset in auto-register mode, stored otherwise.
    always_comb eff = auto_reg ? preset : tim;

    // Port mapping of direct controls and effective timing values.
    always_comb begin
        sinc_en         = ctl2[5];
        comb_en         = ctl2[4];
        chroma_off      = ctl2[3];
        vbi_pass        = ctl2[2];
        blackburst      = ctl2[1];
        freerun         = ctl2[0];
        eff_preemph     = pre;
        eff_hsync_w     = eff[0];
        eff_burst_start = eff[1];
        eff_burst_len   = eff[2];
        eff_luma_gain   = eff[3];
        eff_chroma_gain = eff[4];
        eff_vbi_gain    = eff[5];
    end

    AST_STD_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1[6] |-> (std_sel[1] == line625_det && std_sel[0] == ctl1[4])); // R7
    AST_EFF_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl1[7] |-> (eff_hsync_w == tim[0] && eff_vbi_gain == tim[5])); // R9
    AST_EFF_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1[7] |-> (eff_hsync_w == preset_val(std_sel, 0))); // R8
    AST_CTL1_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTL1) |-> (rdata[3:0] == 4'h0)); // R4
    AST_CTL2_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTL2) |-> (rdata[7:6] == 2'b00)); // R4

endmodule

// File: tb/test_vid_ctl_regbank.sv
module test_vid_ctl_regbank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line625_det = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] std_sel;
    logic       sinc_en, comb_en, chroma_off, vbi_pass, blackburst, freerun;
    logic [7:0] eff_preemph, eff_hsync_w, eff_burst_start, eff_burst_len;
    logic [7:0] eff_luma_gain, eff_chroma_gain, eff_vbi_gain;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_ctl_regbank i_vid_ctl_regbank (
        .clk(clk), .rst_n(rst_n), .line625_det(line625_det), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .std_sel(std_sel),
        .sinc_en(sinc_en), .comb_en(comb_en), .chroma_off(chroma_off), .vbi_pass(vbi_pass),
        .blackburst(blackburst), .freerun(freerun), .eff_preemph(eff_preemph),
        .eff_hsync_w(eff_hsync_w), .eff_burst_start(eff_burst_start), .eff_burst_len(eff_burst_len),
        .eff_luma_gain(eff_luma_gain), .eff_chroma_gain(eff_chroma_gain), .eff_vbi_gain(eff_vbi_gain)
    );

    // Expected presets: row = standard code, column = timing register.
    function automatic logic [7:0] exp_preset(input int std, input int idx);
        int tbl [4][6] = '{'{63, 19, 36, 128, 150, 100},
                           '{62, 20, 37, 120, 144, 102},
                           '{64, 22, 40, 132, 160, 104},
                           '{65, 21, 38, 124, 154, 106}};
        return 8'(tbl[std][idx]);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; addr = a; wdata = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        read_reg(6'h00, d); check("R5 ctl1 reset", d, 8'hC0);
        read_reg(6'h01, d); check("R5 ctl2 reset", d, 8'h30);
        read_reg(6'h02, d); check("R5 pre reset", d, 8'h00);
        read_reg(6'h08, d); check("R5 tim0 reset", d, 8'd63);
        read_reg(6'h0D, d); check("R5 tim5 reset", d, 8'd100);
        check("R5 std_sel", {6'b0, std_sel}, 8'h00);
        check("R5 flags", {2'b0, sinc_en, comb_en, chroma_off, vbi_pass, blackburst, freerun}, 8'h30);
    endtask

    task automatic t_write_basic();
        logic [7:0] d;
        @(negedge clk);
        cs_n = 1'b0; addr = 6'h02; wdata = 8'h5A;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        #1; check("R1 no write while strobe low", rdata, 8'h00);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #1; check("R1 write after rise", rdata, 8'h5A);
        cs_n = 1'b1;
        read_reg(6'h02, d); check("R1 pre readback", d, 8'h5A);
    endtask

    task automatic t_cs_high();
        logic [7:0] d;
        bus_write(6'h02, 8'h11, 1'b1);
        read_reg(6'h02, d); check("R2 cs high ignored", d, 8'h5A);
    endtask

    task automatic t_read_indep();
        @(negedge clk);
        addr = 6'h02; cs_n = 1'b0; wr_n = 1'b0;
        #1; check("R3 read cs/wr low", rdata, 8'h5A);
        @(negedge clk);
        cs_n = 1'b1;
        #1; check("R3 read cs high wr low", rdata, 8'h5A);
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        #1; check("R3 read idle", rdata, 8'h5A);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        bus_write(6'h3F, 8'hFF, 1'b0);
        read_reg(6'h3F, d); check("R4 unused read zero", d, 8'h00);
        read_reg(6'h02, d); check("R4 pre untouched", d, 8'h5A);
        read_reg(6'h01, d); check("R4 ctl2 untouched", d, 8'h30);
        bus_write(6'h01, 8'hFF, 1'b0);
        read_reg(6'h01, d); check("R4 ctl2 high bits zero", d, 8'h3F);
        check("R10 flags follow ctl2", {2'b0, sinc_en, comb_en, chroma_off, vbi_pass, blackburst, freerun}, 8'h3F);
        bus_write(6'h01, 8'h06, 1'b0);
        check("R10 flags second pattern", {2'b0, sinc_en, comb_en, chroma_off, vbi_pass, blackburst, freerun}, 8'h06);
        check("R10 preemph in auto", eff_preemph, 8'h5A);
    endtask

    task automatic t_std_manual();
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            bus_write(6'h00, 8'h80 | 8'(s << 4) | 8'h0F, 1'b0);
            read_reg(6'h00, d); check("R4 ctl1 low bits zero", d, 8'h80 | 8'(s << 4));
            check("R6 manual std", {6'b0, std_sel}, 8'(s));
            check("R8 preset hsync", eff_hsync_w, exp_preset(s, 0));
            check("R8 preset chroma gain", eff_chroma_gain, exp_preset(s, 4));
        end
    endtask

    task automatic t_auto_std();
        bus_write(6'h00, 8'hD0, 1'b0);
        @(negedge clk); line625_det = 1'b1; #1;
        check("R7 auto std 625", {6'b0, std_sel}, 8'h03);
        check("R8 PAL-N burst len", eff_burst_len, 8'd38);
        @(negedge clk); line625_det = 1'b0; #1;
        check("R7 auto std 525", {6'b0, std_sel}, 8'h01);
        check("R8 PAL-M luma gain", eff_luma_gain, 8'd120);
    endtask

    task automatic t_auto_reg();
        logic [7:0] d;
        bus_write(6'h08, 8'hAA, 1'b0);
        read_reg(6'h08, d); check("R8 stored writable in auto", d, 8'hAA);
        check("R8 eff uses preset", eff_hsync_w, 8'd62);
        bus_write(6'h00, 8'h20, 1'b0);
        check("R6 manual PAL", {6'b0, std_sel}, 8'h02);
        check("R9 eff stored hsync", eff_hsync_w, 8'hAA);
        check("R9 eff stored burst start", eff_burst_start, 8'd19);
        check("R10 preemph manual", eff_preemph, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_cs_high();
        t_read_indep();
        t_unused();
        t_std_manual();
        t_auto_std();
        t_auto_reg();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule